// File: doc/BRIEF.md
# Resolution-Selectable Pulse-Density Speaker DAC

This block is the audio output stage of a small speech or sound subsystem. Software or a sample engine writes signed audio samples into a data register. The block turns each sample into a pulse-density bitstream on a pair of complementary output pins, which can drive a loudspeaker directly. Once per sample period it raises a one-cycle request strobe, which asks the source for the next value.

The pulse rate comes from the master clock. An optional prescaler halves it. A two-bit resolution field selects 8, 9 or 10 bits. One sample period always lasts 2^N pulse clocks, so the sample rate is the pulse rate divided by 2^N. For example, 9-bit output at 8 kHz needs a 4.096 MHz pulse clock.

A first-order accumulator modulator produces the density. Within one period, the number of pulse clocks with the positive pin high equals the offset-binary form of the sample. If the source writes nothing new, the last sample repeats. When the resolution changes, the period restarts cleanly. When the block is disabled, both pins stay low.

Top module: `pdm_speaker_dac`

## Requirements
- R1: The resolution field `res_sel` selects N: 00 gives N=8, 01 gives N=9, and 10 or 11 gives N=10. While the field and `half_rate` are unchanged, consecutive `sample_req` strobes are exactly 2^N pulse clocks apart.
- R2: With `half_rate`=0 a pulse clock occurs on every master clock. With `half_rate`=1 it occurs on every second master clock, so the period becomes 2^N*2 master clocks and each pin value is held for two master clocks.
- R3: A sample is read as a two's-complement number from the upper N bits of `wr_data` (bits 9 down to 10-N). In each period, the number of pulse clocks with `pin_p` high equals that value with its top bit inverted, which lies in the range 0 to 2^N-1.
- R4: At N=8 data bits 1:0 have no effect, and at N=9 bit 0 has no effect. Two samples that differ only there produce identical pin densities.
- R5: `sample_req` is high for exactly one master clock at each period boundary. A sample written at least one clock before a boundary is the one played in the period that starts at that boundary, and its first pulse appears on the pins in the same cycle as the strobe.
- R6: If no sample is written during a period, the next period replays the last sample held in the data register.
- R7: While enabled and playing, `pin_n` is always the inverse of `pin_p`. The two pins are never high together.
- R8: A change of the effective resolution clears the period counter and the accumulator. The next pulse clock then starts a full new period, with a strobe no later than two pulse clocks after the change.
- R9: During reset, and on any clock after `enable` is sampled low, both pins are low and `sample_req` stays low. When the block is enabled again, playback starts with a fresh period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Output stage enable |
| res_sel | input | 2 | Resolution select field |
| half_rate | input | 1 | Halve the pulse clock relative to the master clock |
| wr_en | input | 1 | Write strobe for the sample data register |
| wr_data | input | 10 | Signed sample, left aligned |
| sample_req | output | 1 | One-cycle request for the next sample |
| pin_p | output | 1 | Positive pulse-density output |
| pin_n | output | 1 | Complementary pulse-density output |

## Verification
The bench goes after the extreme codes, the most negative and the most positive sample. Off-by-one errors in the accumulator carry or in the offset conversion show there as counts of 1 or 2^N rather than 0 and 2^N-1. Bursts are measured at all three resolutions and at the halved rate. A design that takes the wrong data bits, or keeps the low bits at 8 or 9 bits, gives wrong counts for samples that differ only in the ignored bits. Missed writes show as wrong counts when the bench skips a write. The bench switches the resolution mid-period, including a switch from code 11 to code 10 that must not restart anything. A design that does not restart leaves a long gap before the next strobe, and one that restarts needlessly shortens a period. A disable window checks that the pins go quiet and that playback resumes with the held sample.

// File: rtl/pdm_dac_pkg.sv
package pdm_dac_pkg;

    localparam int DATA_W  = 10;
    localparam int RES_MIN = 8;
    localparam int RES_MAX = 10;
    localparam int NB_W    = $clog2(RES_MAX + 1);
    localparam int CNT_W   = RES_MAX;

    typedef enum logic [1:0] {
        RES_SEL_8   = 2'b00,
        RES_SEL_9   = 2'b01,
        RES_SEL_10  = 2'b10,
        RES_SEL_10X = 2'b11
    } res_sel_e;

    typedef logic [NB_W-1:0]   nbits_t;
    typedef logic [DATA_W-1:0] sample_t;

    typedef struct packed {
        logic    carry;
        sample_t acc;
    } mod_step_t;

    // Map the control field onto a resolution in bits
    function automatic nbits_t res_bits(input res_sel_e sel);
        case (sel)
            RES_SEL_8: return NB_W'(RES_MIN);
            RES_SEL_9: return NB_W'(RES_MIN + 1);
            default:   return NB_W'(RES_MAX);
        endcase
    endfunction

    // Upper nb bits of a left-aligned signed sample, converted to offset binary
    function automatic sample_t offset_code(input sample_t d, input nbits_t nb);
        sample_t s;
        s = d >> (NB_W'(DATA_W) - nb);
        s = s ^ (DATA_W'(1) << (nb - NB_W'(1)));
        return s;
    endfunction

    // Last count value of a period of 2^nb pulse clocks
    function automatic logic [CNT_W-1:0] period_last(input nbits_t nb);
        logic [CNT_W:0] full;
        full = ((CNT_W + 1)'(1) << nb) - (CNT_W + 1)'(1);
        return full[CNT_W-1:0];
    endfunction

    // One step of the first-order accumulator at resolution nb
    function automatic mod_step_t mod_step(input sample_t acc, input sample_t code,
                                           input nbits_t nb);
        mod_step_t      r;
        logic [DATA_W:0] sum;
        logic [DATA_W:0] mask;
        sum     = {1'b0, acc} + {1'b0, code};
        mask    = ((DATA_W + 1)'(1) << nb) - (DATA_W + 1)'(1);
        r.carry = sum[nb];
        r.acc   = sum[DATA_W-1:0] & mask[DATA_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/pdm_prescaler.sv
module pdm_prescaler (
    input  logic clk,
    input  logic rst,
    input  logic half_rate,
    output logic tick
);
    logic phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b0;
        end else if (half_rate) begin
            phase <= ~phase;
        end else begin
            phase <= 1'b0;
        end
    end

    always_comb begin
        tick = !half_rate || phase;
    end
endmodule

// File: rtl/pdm_sequencer.sv
module pdm_sequencer
    import pdm_dac_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    enable,
    input  logic    tick,
    input  nbits_t  nb,
    input  sample_t data_q,
    output sample_t code,
    output logic    restart,
    output logic    sample_req
);
    logic [CNT_W-1:0] cnt;
    sample_t          work;
    sample_t          load;
    nbits_t           nb_q;
    logic             boundary;

    always_comb begin
        load     = offset_code(data_q, nb);
        restart  = !enable || (nb != nb_q);
        boundary = tick && !restart && (cnt == '0);
        code     = boundary ? load : work;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            work       <= '0;
            nb_q       <= nb;
            sample_req <= 1'b0;
        end else begin
            nb_q       <= nb;
            sample_req <= boundary;
            if (restart) begin
                cnt <= '0;
            end else if (tick) begin
                cnt <= (cnt == period_last(nb)) ? '0 : cnt + CNT_W'(1);
                if (boundary) begin
                    work <= load;
                end
            end
        end
    end
endmodule

// File: rtl/pdm_modulator.sv
module pdm_modulator
    import pdm_dac_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    enable,
    input  logic    restart,
    input  logic    tick,
    input  nbits_t  nb,
    input  sample_t code,
    output logic    pin_p,
    output logic    pin_n
);
    sample_t   acc;
    mod_step_t step;

    always_comb begin
        step = mod_step(acc, code, nb);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            acc   <= '0;
            pin_p <= 1'b0;
            pin_n <= 1'b0;
        end else if (restart) begin
            acc <= '0;
        end else if (tick) begin
            acc   <= step.acc;
            pin_p <= step.carry;
            pin_n <= ~step.carry;
        end
    end
endmodule

// File: rtl/pdm_speaker_dac.sv
module pdm_speaker_dac
    import pdm_dac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [1:0]        res_sel,
    input  logic              half_rate,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sample_req,
    output logic              pin_p,
    output logic              pin_n
);
    sample_t data_q;
    sample_t code;
    nbits_t  nb;
    logic    pdm_tick;
    logic    restart;

    always_comb begin
        nb = res_bits(res_sel_e'(res_sel));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (wr_en) begin
            data_q <= wr_data;
        end
    end

    pdm_prescaler u_pre (
        .clk       (clk),
        .rst       (rst),
        .half_rate (half_rate),
        .tick      (pdm_tick)
    );

    pdm_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .tick       (pdm_tick),
        .nb         (nb),
        .data_q     (data_q),
        .code       (code),
        .restart    (restart),
        .sample_req (sample_req)
    );

    pdm_modulator u_mod (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .restart (restart),
        .tick    (pdm_tick),
        .nb      (nb),
        .code    (code),
        .pin_p   (pin_p),
        .pin_n   (pin_n)
    );
endmodule

// File: rtl/pdm_dac_checker.sv
module pdm_dac_checker (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic half_rate,
    input logic tick,
    input logic sample_req,
    input logic pin_p,
    input logic pin_n
);
    // R5
    req_single_chk: assert property (@(posedge clk) disable iff (rst)
        sample_req |=> !sample_req);

    // R7
    pins_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pin_p && pin_n));

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!pin_p && !pin_n && !sample_req));

    // R2
    half_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (half_rate && tick) |=> (!tick || !half_rate));

    // R2
    pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && !tick) |=> ($stable(pin_p) && $stable(pin_n)));
endmodule

bind pdm_speaker_dac pdm_dac_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .half_rate  (half_rate),
    .tick       (pdm_tick),
    .sample_req (sample_req),
    .pin_p      (pin_p),
    .pin_n      (pin_n)
);

// File: tb/sim_pdm_speaker_dac.sv
module sim_pdm_speaker_dac;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b1;
    logic [1:0] res_sel = 2'b00;
    logic       half_rate = 1'b0;
    logic       wr_en = 1'b0;
    logic [9:0] wr_data = '0;
    logic       sample_req, pin_p, pin_n;

    pdm_speaker_dac u0 (
        .clk(clk), .rst(rst), .enable(enable), .res_sel(res_sel),
        .half_rate(half_rate), .wr_en(wr_en), .wr_data(wr_data),
        .sample_req(sample_req), .pin_p(pin_p), .pin_n(pin_n)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    ones;
        string tag;
    } exp_t;

    exp_t       q[$];
    int         checks = 0;
    int         fails = 0;
    int         cur_n = 8;
    int         cur_div = 1;
    logic [9:0] last_v = '0;
    bit         mon_on = 1'b1;
    bit         done = 1'b0;

    // monitor state
    bit    in_win = 1'b0;
    bit    has_exp = 1'b0;
    bit    prev_req = 1'b0;
    bit    dup_req = 1'b0;
    bit    compl_bad = 1'b0;
    int    win_len = 0;
    int    ones = 0;
    exp_t  cur_exp;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic int code_of(input logic [9:0] v, input int n);
        int t;
        t = int'(v) >> (10 - n);
        return t ^ (1 << (n - 1));
    endfunction

    task automatic push_exp(input logic [9:0] v, input string tag);
        exp_t e;
        e.ones = code_of(v, cur_n) * cur_div;
        e.tag  = tag;
        q.push_back(e);
    endtask

    // Monitor: one window per period, opened by each strobe
    always @(negedge clk) begin
        if (!rst && mon_on) begin
            if (sample_req && prev_req) dup_req = 1'b1;
            if (sample_req) begin
                if (in_win) begin
                    chk(win_len == (1 << cur_n) * cur_div,
                        (cur_div == 2) ? "R2" : "R1", "period length",
                        win_len, (1 << cur_n) * cur_div);
                    if (has_exp)
                        chk(ones == cur_exp.ones, cur_exp.tag, "pin_p high count",
                            ones, cur_exp.ones);
                    chk(!compl_bad, "R7", "pin_n inverse of pin_p", compl_bad, 0);
                    chk(!dup_req, "R5", "single-cycle strobe", dup_req, 0);
                end
                in_win    = 1'b1;
                win_len   = 0;
                ones      = 0;
                compl_bad = 1'b0;
                dup_req   = 1'b0;
                has_exp   = (q.size() > 0);
                if (has_exp) cur_exp = q.pop_front();
            end
            if (in_win) begin
                win_len++;
                if (pin_p) ones++;
                if (pin_n == pin_p) compl_bad = 1'b1;
            end
        end
        prev_req = sample_req;
    end

    task automatic wait_req();
        @(negedge clk);
        while (!sample_req) @(negedge clk);
    endtask

    // Driver: write after a strobe, so the value plays from the next boundary
    task automatic send_raw(input logic [9:0] v, input bit wr, input string tag);
        wait_req();
        #1;
        if (wr) begin
            wr_en   = 1'b1;
            wr_data = v;
            last_v  = v;
        end
        push_exp(last_v, tag);
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic send_s(input int s, input string tag);
        send_raw(10'(s << (10 - cur_n)), 1'b1, tag);
    endtask

    task automatic drain();
        wait_req();
        wait_req();
        #1;
    endtask

    task automatic set_res(input logic [1:0] rs, input bit half, input bit restart_expected);
        int k;
        bit found;
        @(negedge clk);
        #1;
        res_sel   = rs;
        half_rate = half;
        if (restart_expected) begin
            in_win  = 1'b0;
            q.delete();
            cur_n   = (rs == 2'b00) ? 8 : (rs == 2'b01) ? 9 : 10;
            cur_div = half ? 2 : 1;
            push_exp(last_v, "R8");
            k = 0;
            found = 1'b0;
            while (!found && k < 8) begin
                @(negedge clk);
                k++;
                if (sample_req) found = 1'b1;
            end
            chk(found && k <= 2 * cur_div + 1, "R8", "clocks to first strobe after change",
                k, 2 * cur_div + 1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int bad;
        repeat (5) @(negedge clk);
        // R9: reset state
        chk(!pin_p && !pin_n && !sample_req, "R9", "outputs during reset",
            {pin_p, pin_n, sample_req}, 0);
        #1 rst = 1'b0;

        // 8-bit, full rate: extremes, midscale, repeat, ignored low bits
        send_s(-128, "R3");
        send_s(127, "R3");
        send_s(0, "R3");
        send_s(45, "R3");
        send_raw(10'h000, 1'b0, "R6");
        send_s(-77, "R3");
        send_raw(10'h0FF, 1'b1, "R4");
        send_raw(10'h0FC, 1'b1, "R4");
        drain();

        // 9-bit
        set_res(2'b01, 1'b0, 1'b1);
        send_s(-256, "R3");
        send_s(255, "R3");
        send_s(100, "R3");
        send_raw(10'h001, 1'b1, "R4");
        send_raw(10'h000, 1'b1, "R4");
        drain();

        // code 11 acts as 10 bits
        set_res(2'b11, 1'b0, 1'b1);
        send_s(-512, "R3");
        send_s(511, "R3");
        send_s(-1, "R3");
        send_raw(10'h000, 1'b0, "R6");
        send_s(300, "R3");
        drain();

        // code 10 is the same resolution: no restart, R1
        set_res(2'b10, 1'b0, 1'b0);
        send_s(-200, "R1");
        send_s(17, "R1");
        drain();

        // halved pulse clock at 8 bits
        set_res(2'b00, 1'b1, 1'b1);
        send_s(-128, "R2");
        send_s(127, "R2");
        send_s(-5, "R2");
        send_raw(10'h000, 1'b0, "R6");
        drain();

        // disable window
        @(negedge clk);
        #1;
        enable = 1'b0;
        mon_on = 1'b0;
        in_win = 1'b0;
        q.delete();
        bad = 0;
        repeat (64) begin
            @(negedge clk);
            if (pin_p || pin_n || sample_req) bad++;
        end
        chk(bad == 0, "R9", "active outputs while disabled", bad, 0);
        #1;
        push_exp(last_v, "R9");
        enable = 1'b1;
        mon_on = 1'b1;
        send_s(60, "R3");
        send_s(-60, "R3");
        drain();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule